// File: doc/BRIEF.md
# Operand-Wakeup Reservation Station

This block is a small multi-slot holding buffer that sits in front of a single functional unit. The issue stage hands it one instruction per cycle: an opcode, a destination tag, and two source operands. Each operand arrives either as a finished value or as the tag of the instruction that will produce it. Instructions with missing operands park in a slot. They listen to a result broadcast bus (tag plus value) and pick up each operand as soon as its producer finishes.

Once both operands are present, the instruction becomes eligible. The station hands one eligible instruction per cycle to the functional unit, as long as that unit does not report busy. Among eligible instructions, the one allocated earliest goes first. Older instructions that are still waiting do not block younger ones that are complete, so dispatch runs out of program order. An instruction whose operands are complete at issue can leave in the very next cycle. A flush input empties the whole station in one cycle.

Each slot is a three-state machine. The states are SLOT_FREE (unoccupied), SLOT_WAIT (occupied, an operand missing) and SLOT_READY (occupied, both operands present). The transitions are:

| Transition | Condition |
|---|---|
| FREE to WAIT (alloc_wait) | The slot is allocated and an operand is still missing after same-cycle capture. |
| FREE to READY (alloc_ready) | The slot is allocated with both operands present. |
| WAIT to WAIT (partial_capture) | One operand is captured and the other is still missing. |
| WAIT to READY (wakeup) | The last missing operand is captured from the broadcast. |
| READY to FREE (dispatch) | The slot is granted. |
| any to FREE (flush) | The flush input is high. |

Top module: `rs_station`

## Requirements
- R1: After reset, `iss_ready` is 1 and `dsp_valid` is 0.
- R2: An instruction is accepted at a clock edge where both `iss_valid` and `iss_ready` are high. `iss_ready` is low exactly when all NUM_SLOTS slots are occupied, and an offer made while it is low is dropped.
- R3: `dsp_valid` is high only while an occupied slot holds both operands, `fu_busy` is low and `flush` is low. While it is high, `dsp_op`, `dsp_dst`, `dsp_a` and `dsp_b` carry that slot's opcode, destination tag and two operand values.
- R4: An instruction accepted at edge k with both operands flagged present appears on the dispatch port in the cycle after edge k if `fu_busy` is low, so it spends zero cycles waiting.
- R5: A waiting operand whose producer tag equals `bc_tag` while `bc_valid` is high takes `bc_val` at that edge. The instruction can be dispatched in the cycle after the edge that supplied its last operand.
- R6: A broadcast whose tag matches a missing operand of the instruction being accepted in the same cycle is captured into that instruction.
- R7: When several slots are dispatchable, the one allocated earliest is dispatched. An older instruction that is still waiting does not hold back a younger complete one.
- R8: At most one instruction is dispatched per cycle. A dispatched instruction leaves the station and is never dispatched again.
- R9: A high `flush` empties every slot at that edge, discards an instruction offered in the same cycle, and suppresses dispatch in that cycle.
- R10: A broadcast with a non-matching tag, or with `bc_valid` low, leaves waiting operands untouched. An operand that is already present is never overwritten by a later broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all slots |
| iss_valid | input | 1 | Issue offer valid |
| iss_ready | output | 1 | A free slot exists |
| iss_op | input | OP_W | Opcode of the offered instruction |
| iss_dst | input | TAG_W | Destination tag |
| iss_a_rdy | input | 1 | Operand A value present |
| iss_a_tag | input | TAG_W | Producer tag of A when absent |
| iss_a_val | input | DATA_W | Value of A when present |
| iss_b_rdy | input | 1 | Operand B value present |
| iss_b_tag | input | TAG_W | Producer tag of B when absent |
| iss_b_val | input | DATA_W | Value of B when present |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| fu_busy | input | 1 | Functional unit cannot accept |
| dsp_valid | output | 1 | Instruction handed to the unit this cycle |
| dsp_op | output | OP_W | Dispatched opcode |
| dsp_dst | output | TAG_W | Dispatched destination tag |
| dsp_a | output | DATA_W | Dispatched operand A |
| dsp_b | output | DATA_W | Dispatched operand B |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a result broadcast and the allocation of an instruction that needs that result. The bench provokes this with a directed case that issues an instruction waiting on a tag while the same tag is on the broadcast bus. Random stimulus also draws source tags and broadcast tags from a deliberately small tag range, so such collisions happen often. The bench judges the outcome by whether the instruction leaves one cycle later carrying the broadcast value.

The second pair is a dispatch and an allocation at the same edge while the station is near full. A bench model that tracks slot contents and allocation order predicts `iss_ready`, the selected instruction and its fields in every cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;

endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc,
    input  logic [OP_W-1:0]   in_op,
    input  logic [TAG_W-1:0]  in_dst,
    input  logic              in_a_rdy,
    input  logic [TAG_W-1:0]  in_a_tag,
    input  logic [DATA_W-1:0] in_a_val,
    input  logic              in_b_rdy,
    input  logic [TAG_W-1:0]  in_b_tag,
    input  logic [DATA_W-1:0] in_b_val,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    input  logic              grant,
    output logic              is_free,
    output logic              is_ready,
    output logic [OP_W-1:0]   out_op,
    output logic [TAG_W-1:0]  out_dst,
    output logic [DATA_W-1:0] out_a,
    output logic [DATA_W-1:0] out_b
);

    slot_state_e       state_q, state_d;
    logic [OP_W-1:0]   op_q;
    logic [TAG_W-1:0]  dst_q;
    logic              a_have_q, b_have_q;
    logic [TAG_W-1:0]  a_tag_q, b_tag_q;
    logic [DATA_W-1:0] a_val_q, b_val_q;

    // wakeup matches for a parked instruction
    logic a_hit, b_hit;
    // same-cycle capture for the instruction being allocated
    logic in_a_hit, in_b_hit, in_a_ok, in_b_ok;

    always_comb begin
        a_hit    = bc_valid && (state_q == SLOT_WAIT) && !a_have_q && (a_tag_q == bc_tag);
        b_hit    = bc_valid && (state_q == SLOT_WAIT) && !b_have_q && (b_tag_q == bc_tag);
        in_a_hit = bc_valid && !in_a_rdy && (in_a_tag == bc_tag);
        in_b_hit = bc_valid && !in_b_rdy && (in_b_tag == bc_tag);
        in_a_ok  = in_a_rdy || in_a_hit;
        in_b_ok  = in_b_rdy || in_b_hit;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (alloc) state_d = (in_a_ok && in_b_ok) ? SLOT_READY : SLOT_WAIT;
            end
            SLOT_WAIT: begin
                if ((a_have_q || a_hit) && (b_have_q || b_hit)) state_d = SLOT_READY;
            end
            SLOT_READY: begin
                if (grant) state_d = SLOT_FREE;
            end
            default: state_d = SLOT_FREE;
        endcase
        if (flush) state_d = SLOT_FREE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // payload and operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= '0;
            dst_q    <= '0;
            a_have_q <= 1'b0;
            b_have_q <= 1'b0;
            a_tag_q  <= '0;
            b_tag_q  <= '0;
            a_val_q  <= '0;
            b_val_q  <= '0;
        end else if (alloc && state_q == SLOT_FREE) begin
            op_q     <= in_op;
            dst_q    <= in_dst;
            a_have_q <= in_a_ok;
            b_have_q <= in_b_ok;
            a_tag_q  <= in_a_tag;
            b_tag_q  <= in_b_tag;
            a_val_q  <= in_a_rdy ? in_a_val : bc_val;
            b_val_q  <= in_b_rdy ? in_b_val : bc_val;
        end else begin
            if (a_hit) begin
                a_have_q <= 1'b1;
                a_val_q  <= bc_val;
            end
            if (b_hit) begin
                b_have_q <= 1'b1;
                b_val_q  <= bc_val;
            end
        end
    end

    // outputs
    always_comb begin
        is_free  = (state_q == SLOT_FREE);
        is_ready = (state_q == SLOT_READY);
        out_op   = op_q;
        out_dst  = dst_q;
        out_a    = a_val_q;
        out_b    = b_val_q;
    end

    assert_grant_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> state_q == SLOT_READY);

    assert_alloc_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> state_q == SLOT_FREE);

    assert_ready_ops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SLOT_READY |-> (a_have_q && b_have_q));

    assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_WAIT && !flush && !bc_valid) |=> state_q == SLOT_WAIT);

endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] alloc_vec,
    input  logic [NUM_SLOTS-1:0] occ,
    input  logic [NUM_SLOTS-1:0] ready,
    input  logic                 grant_en,
    output logic [NUM_SLOTS-1:0] grant,
    output logic                 any_ready
);

    // older_q[i][j] set: slot j was allocated before slot i
    logic [NUM_SLOTS-1:0] older_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] cand;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n)
                older_q[i] <= '0;
            else if (alloc_vec[i])
                older_q[i] <= occ & ~(NUM_SLOTS'(1) << i);
            else
                older_q[i] <= older_q[i] & ~alloc_vec;
        end
        assign cand[i] = ready[i] && ((older_q[i] & ready) == '0);
    end

    always_comb begin
        any_ready = |ready;
        grant     = grant_en ? cand : '0;
    end

    assert_onehot_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_pick_exists_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_en && any_ready) |-> $countones(grant) == 1);

endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int OP_W      = 4,
    parameter int TAG_W     = 4,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_dst,
    input  logic              iss_a_rdy,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic              iss_b_rdy,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    input  logic              fu_busy,
    output logic              dsp_valid,
    output logic [OP_W-1:0]   dsp_op,
    output logic [TAG_W-1:0]  dsp_dst,
    output logic [DATA_W-1:0] dsp_a,
    output logic [DATA_W-1:0] dsp_b
);

    logic [NUM_SLOTS-1:0] free_vec, ready_vec, alloc_vec, grant_vec;
    logic                 any_ready, grant_en, accept;
    logic [OP_W-1:0]      s_op  [NUM_SLOTS];
    logic [TAG_W-1:0]     s_dst [NUM_SLOTS];
    logic [DATA_W-1:0]    s_a   [NUM_SLOTS];
    logic [DATA_W-1:0]    s_b   [NUM_SLOTS];

    // lowest free slot takes the offered instruction
    always_comb begin
        alloc_vec = '0;
        accept    = iss_valid && iss_ready && !flush;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (free_vec[i]) alloc_vec = NUM_SLOTS'(1) << i;
        end
        if (!accept) alloc_vec = '0;
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        rs_slot #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .alloc    (alloc_vec[i]),
            .in_op    (iss_op),
            .in_dst   (iss_dst),
            .in_a_rdy (iss_a_rdy),
            .in_a_tag (iss_a_tag),
            .in_a_val (iss_a_val),
            .in_b_rdy (iss_b_rdy),
            .in_b_tag (iss_b_tag),
            .in_b_val (iss_b_val),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_val   (bc_val),
            .grant    (grant_vec[i]),
            .is_free  (free_vec[i]),
            .is_ready (ready_vec[i]),
            .out_op   (s_op[i]),
            .out_dst  (s_dst[i]),
            .out_a    (s_a[i]),
            .out_b    (s_b[i])
        );
    end

    assign grant_en = !fu_busy && !flush;

    rs_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_vec (alloc_vec),
        .occ       (~free_vec),
        .ready     (ready_vec),
        .grant_en  (grant_en),
        .grant     (grant_vec),
        .any_ready (any_ready)
    );

    // dispatch port
    always_comb begin
        iss_ready = |free_vec;
        dsp_valid = grant_en && any_ready;
        dsp_op    = '0;
        dsp_dst   = '0;
        dsp_a     = '0;
        dsp_b     = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (grant_vec[i]) begin
                dsp_op  = dsp_op  | s_op[i];
                dsp_dst = dsp_dst | s_dst[i];
                dsp_a   = dsp_a   | s_a[i];
                dsp_b   = dsp_b   | s_b[i];
            end
        end
    end

    assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fu_busy |-> !dsp_valid);

    assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!dsp_valid && iss_ready));

endmodule

// File: tb/rs_station_bench.sv
module rs_station_bench;

    localparam int N  = 4;
    localparam int OW = 4;
    localparam int TW = 4;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 0, iss_valid = 0, iss_a_rdy = 0, iss_b_rdy = 0, bc_valid = 0, fu_busy = 0;
    logic [OW-1:0] iss_op = '0;
    logic [TW-1:0] iss_dst = '0, iss_a_tag = '0, iss_b_tag = '0, bc_tag = '0;
    logic [DW-1:0] iss_a_val = '0, iss_b_val = '0, bc_val = '0;
    logic iss_ready, dsp_valid;
    logic [OW-1:0] dsp_op;
    logic [TW-1:0] dsp_dst;
    logic [DW-1:0] dsp_a, dsp_b;

    always #10 clk = ~clk;

    rs_station #(.NUM_SLOTS(N), .OP_W(OW), .TAG_W(TW), .DATA_W(DW)) u_rs_station (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_a_rdy(iss_a_rdy), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
        .iss_b_rdy(iss_b_rdy), .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val), .fu_busy(fu_busy),
        .dsp_valid(dsp_valid), .dsp_op(dsp_op), .dsp_dst(dsp_dst), .dsp_a(dsp_a), .dsp_b(dsp_b)
    );

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    // bench model of the slots
    int m_st [N];   // 0 free, 1 occupied
    int m_op [N], m_dst [N], m_seq [N];
    int m_ah [N], m_at [N], m_av [N];
    int m_bh [N], m_bt [N], m_bv [N];
    int seq_ctr = 0;
    int exp_idx;
    bit exp_ready, exp_valid;
    bit s_valid, s_ready;
    int s_dst, s_a, s_b, s_op;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_st[i] = 0;
    endtask

    task automatic predict();
        int best_seq;
        exp_ready = 0;
        exp_idx = -1;
        best_seq = 0;
        for (int i = 0; i < N; i++) begin
            if (m_st[i] == 0) exp_ready = 1;
            if (m_st[i] == 1 && m_ah[i] == 1 && m_bh[i] == 1) begin
                if (exp_idx < 0 || m_seq[i] < best_seq) begin
                    exp_idx = i;
                    best_seq = m_seq[i];
                end
            end
        end
        exp_valid = !flush && !fu_busy && (exp_idx >= 0);
    endtask

    task automatic model_update();
        bit was_free [N];
        int slot;
        for (int i = 0; i < N; i++) was_free[i] = (m_st[i] == 0);
        if (flush) begin
            model_reset();
        end else begin
            if (exp_valid) m_st[exp_idx] = 0;
            for (int i = 0; i < N; i++) begin
                if (m_st[i] == 1 && bc_valid) begin
                    if (m_ah[i] == 0 && m_at[i] == int'(bc_tag)) begin m_ah[i] = 1; m_av[i] = int'(bc_val); end
                    if (m_bh[i] == 0 && m_bt[i] == int'(bc_tag)) begin m_bh[i] = 1; m_bv[i] = int'(bc_val); end
                end
            end
            if (iss_valid && exp_ready) begin
                slot = -1;
                for (int i = 0; i < N; i++) if (was_free[i] && slot < 0) slot = i;
                m_st[slot] = 1;
                m_op[slot] = int'(iss_op);
                m_dst[slot] = int'(iss_dst);
                m_seq[slot] = seq_ctr;
                seq_ctr++;
                m_at[slot] = int'(iss_a_tag);
                m_bt[slot] = int'(iss_b_tag);
                m_ah[slot] = iss_a_rdy ? 1 : 0;
                m_av[slot] = int'(iss_a_val);
                m_bh[slot] = iss_b_rdy ? 1 : 0;
                m_bv[slot] = int'(iss_b_val);
                if (bc_valid && !iss_a_rdy && iss_a_tag == bc_tag) begin m_ah[slot] = 1; m_av[slot] = int'(bc_val); end
                if (bc_valid && !iss_b_rdy && iss_b_tag == bc_tag) begin m_bh[slot] = 1; m_bv[slot] = int'(bc_val); end
            end
        end
    endtask

    // one clock: inputs already driven after the falling edge
    task automatic cycle();
        #5;
        predict();
        chk("R2 iss_ready", int'(iss_ready), int'(exp_ready));
        chk("R3 dsp_valid", int'(dsp_valid), int'(exp_valid));
        if (exp_valid && dsp_valid) begin
            chk("R7 dsp_dst", int'(dsp_dst), m_dst[exp_idx]);
            chk("R3 dsp_op", int'(dsp_op), m_op[exp_idx]);
            chk("R3 dsp_a", int'(dsp_a), m_av[exp_idx]);
            chk("R3 dsp_b", int'(dsp_b), m_bv[exp_idx]);
        end
        s_valid = dsp_valid; s_ready = iss_ready;
        s_dst = int'(dsp_dst); s_a = int'(dsp_a); s_b = int'(dsp_b); s_op = int'(dsp_op);
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic quiet();
        iss_valid = 0; bc_valid = 0; flush = 0;
    endtask

    task automatic offer(input int dst, input bit ar, input int at, input int av,
                         input bit br, input int bt, input int bv);
        iss_valid = 1; iss_op = OW'(dst + 1); iss_dst = TW'(dst);
        iss_a_rdy = ar; iss_a_tag = TW'(at); iss_a_val = DW'(av);
        iss_b_rdy = br; iss_b_tag = TW'(bt); iss_b_val = DW'(bv);
    endtask

    task automatic do_flush();
        quiet(); flush = 1; cycle(); flush = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        #5;
        chk("R1 reset iss_ready", int'(iss_ready), 1);
        chk("R1 reset dsp_valid", int'(dsp_valid), 0);
        @(negedge clk);
        rst_n = 1;

        // R4: operands complete at issue, leaves next cycle
        fu_busy = 0;
        offer(3, 1, 0, 16'h00a1, 1, 0, 16'h00b1); cycle();
        quiet(); cycle();
        chk("R4 zero-wait dispatch", int'(s_valid), 1);
        chk("R4 operand a", s_a, 16'h00a1);

        // R5 / R10: wait on tag 5, wrong tag ignored, right tag wakes
        offer(4, 0, 5, 0, 1, 0, 16'h0022); cycle();
        quiet(); cycle();
        chk("R5 waits without operand", int'(s_valid), 0);
        bc_valid = 1; bc_tag = 6; bc_val = 16'hdead; cycle();
        quiet(); cycle();
        chk("R10 mismatched tag ignored", int'(s_valid), 0);
        bc_valid = 1; bc_tag = 5; bc_val = 16'h1234; cycle();
        chk("R5 not yet ready at capture edge", int'(s_valid), 0);
        quiet(); cycle();
        chk("R5 dispatched after wakeup", int'(s_valid), 1);
        chk("R5 captured value", s_a, 16'h1234);

        // R6: broadcast in the same cycle as issue
        offer(7, 0, 7, 0, 1, 0, 16'h0033); bc_valid = 1; bc_tag = 7; bc_val = 16'h4567; cycle();
        quiet(); cycle();
        chk("R6 same-cycle capture dispatch", int'(s_valid), 1);
        chk("R6 same-cycle value", s_a, 16'h4567);

        // R10: present operand not overwritten
        fu_busy = 1;
        offer(2, 1, 3, 16'h0011, 1, 3, 16'h0012); cycle();
        quiet(); bc_valid = 1; bc_tag = 3; bc_val = 16'h0999; cycle();
        quiet(); fu_busy = 0; cycle();
        chk("R10 present operand kept", s_a, 16'h0011);

        // R7: out of order and oldest first
        do_flush();
        fu_busy = 1;
        offer(9, 0, 9, 0, 1, 0, 1); cycle();
        offer(10, 1, 0, 2, 1, 0, 3); cycle();
        offer(11, 1, 0, 4, 1, 0, 5); cycle();
        quiet(); fu_busy = 0; cycle();
        chk("R7 younger ready passes waiting", s_dst, 10);
        cycle();
        chk("R7 oldest ready next", s_dst, 11);
        bc_valid = 1; bc_tag = 9; bc_val = 16'h0077; cycle();
        quiet(); cycle();
        chk("R7 woken oldest leaves", s_dst, 9);

        // R2 / R8: fill, overflow offer dropped, one per cycle drain
        do_flush();
        fu_busy = 1;
        for (int i = 0; i < N; i++) begin offer(i, 1, 0, i, 1, 0, i); cycle(); end
        offer(15, 1, 0, 0, 1, 0, 0); cycle();
        chk("R2 full blocks issue", int'(s_ready), 0);
        quiet(); fu_busy = 0;
        for (int i = 0; i < N; i++) begin
            cycle();
            chk("R8 one dispatch per cycle", s_dst, i);
        end
        cycle();
        chk("R8 dropped offer never dispatched", int'(s_valid), 0);

        // R9: flush with a concurrent offer
        fu_busy = 1;
        offer(1, 1, 0, 1, 1, 0, 1); cycle();
        offer(2, 1, 0, 1, 1, 0, 1); fu_busy = 0; flush = 1; cycle();
        chk("R9 no dispatch in flush cycle", int'(s_valid), 0);
        quiet(); cycle();
        chk("R9 empty after flush", int'(s_valid), 0);
        chk("R9 issue open after flush", int'(s_ready), 1);

        // random phase
        for (int k = 0; k < 3000; k++) begin
            iss_valid = ($urandom % 100) < 60;
            iss_op    = OW'($urandom);
            iss_dst   = TW'($urandom);
            iss_a_rdy = ($urandom % 2) == 0;
            iss_a_tag = TW'($urandom % 8);
            iss_a_val = DW'($urandom);
            iss_b_rdy = ($urandom % 2) == 0;
            iss_b_tag = TW'($urandom % 8);
            iss_b_val = DW'($urandom);
            bc_valid  = ($urandom % 100) < 55;
            bc_tag    = TW'($urandom % 8);
            bc_val    = DW'($urandom);
            fu_busy   = ($urandom % 100) < 30;
            flush     = ($urandom % 100) < 2;
            cycle();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule